// File: doc/BRIEF.md
# Differential Clock Output Gating Controller

This block is the digital control that sits around a clock fan-out buffer with ten true/complement output pairs and one feedback pair. It selects the clock that feeds the outputs: either the reference input directly (bypass, with the PLL switched off) or the PLL output clock. It applies a per-pair enable taken from a 48-bit configuration bus written by a serial slave. The PLL itself, phase comparison and pad electrics lie outside it.

A reference-frequency monitor runs on a free-running system clock. It synchronises the reference, counts its rising edges over a fixed window of system cycles and compares the count with a threshold. The default is 20 edges per 1 us window at 200 MHz, which is a 20 MHz limit. While the reference is judged too slow, every clock output is released to high impedance and the PLL is held off. Enable changes are taken in only while the selected source clock is low, so a pair never emits a shortened pulse.

Top module: `clkfan_gate_ctrl`

## Requirements
- R1: The reference is judged valid only after two consecutive windows of `WIN_CYCLES` system cycles each counted at least `MIN_EDGES` rising reference edges. A window that counts fewer makes it invalid at that window's end. After reset it is invalid.
- R2: While the reference is invalid, `out_oe`, `fb_oe` and `pll_en` are 0 and every true and complement output is driven 0.
- R3: With `bypass_sel` = 1 and a valid reference, `pll_en` is 0 and each enabled pair drives true equal to `ref_clk` and complement equal to its inverse.
- R4: With `bypass_sel` = 0 and a valid reference, `pll_en` is 1 and each enabled pair drives true equal to `pll_clk` and complement equal to its inverse.
- R5: Bit `7-i` of `cfg_bus` enables pair i, for i = 0 to 7. A 1 enables the pair.
- R6: `cfg_bus[15]` enables pair 8 and `cfg_bus[14]` enables pair 9. Bits 13..8 and 47..16 have no effect on any output.
- R7: A disabled pair with `out_oe` = 1 drives true 0 and complement 1.
- R8: While `fb_oe` = 1, `fb_t` follows the selected source clock and `fb_c` its inverse, whatever the enable bits are.
- R9: An enable change reaches a pair only while the selected source clock is low. A pair disabled during a high phase finishes that phase. A pair enabled during a high phase stays low until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running system clock that times the frequency monitor |
| sys_rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | Reference clock input |
| bypass_sel | input | 1 | 1 selects bypass: reference drives the outputs, PLL off |
| pll_clk | input | 1 | PLL output clock |
| cfg_bus | input | 48 | Configuration bytes from the serial slave, byte k at bits 8k+7..8k |
| out_t | output | 10 | True outputs of the ten pairs |
| out_c | output | 10 | Complement outputs of the ten pairs |
| out_oe | output | 1 | Output enable for all pairs; 0 means high impedance |
| fb_t | output | 1 | True feedback output |
| fb_c | output | 1 | Complement feedback output |
| fb_oe | output | 1 | Output enable for the feedback pair |
| pll_en | output | 1 | PLL enable |

## Verification
The bench walks a single enable, and then a single disable, across all ten pairs in both source modes. A wrong bit map would then light the wrong pair, and a swapped source would show the PLL clock in bypass. It sets every ignored configuration bit and expects identical outputs, which catches decoding that reaches into the spare bits. It starts and slows the reference around the window boundaries: a monitor that trusts one good window turns valid too early, and one that misses a short window keeps driving a slow clock. It also flips an enable in the middle of a high phase, which exposes gating that is not held to the low phase because the pulse is then cut short or starts late.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

   localparam int NUM_PAIRS = 10;
   localparam int CFG_BYTES = 6;
   localparam int CFG_W     = CFG_BYTES * 8;

   typedef logic [NUM_PAIRS-1:0] pair_vec_t;

   // Position in the configuration bus of the enable bit for a pair:
   // pairs 0..7 use byte 0 from bit 7 downward, pairs 8..9 use byte 1 from bit 7 downward.
   function automatic int enable_bit_pos(input int pair);
      if (pair < 8) return 7 - pair;
      else          return 15 - (pair - 8);
   endfunction

endpackage

// File: rtl/clkfan_freq_mon.sv
module clkfan_freq_mon #(
   parameter int WIN_CYCLES  = 200,
   parameter int MIN_EDGES   = 20,
   parameter int SYNC_STAGES = 3
) (
   input  logic sys_clk,
   input  logic sys_rst_n,
   input  logic ref_clk,
   output logic freq_ok
);

   localparam int WIN_W = $clog2(WIN_CYCLES);
   localparam int CNT_W = $clog2(MIN_EDGES + 1);
   localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MIN_EDGES);

   if (SYNC_STAGES < 3) begin : g_bad_sync
      $error("clkfan_freq_mon: SYNC_STAGES must be at least 3");
   end
   if (MIN_EDGES < 1 || MIN_EDGES >= WIN_CYCLES) begin : g_bad_thresh
      $error("clkfan_freq_mon: MIN_EDGES must lie in 1..WIN_CYCLES-1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [WIN_W-1:0]       win_cnt;
   logic [CNT_W-1:0]       edge_cnt;
   logic                   prev_hit;
   logic                   ref_rise;
   logic                   win_end;
   logic                   win_hit;

   always_ff @(posedge sys_clk or negedge sys_rst_n) begin
      if (!sys_rst_n) sync_q <= '0;
      else            sync_q <= {sync_q[SYNC_STAGES-2:0], ref_clk};
   end

   assign ref_rise = sync_q[SYNC_STAGES-2] & ~sync_q[SYNC_STAGES-1];
   assign win_end  = (win_cnt == WIN_LAST);
   assign win_hit  = (edge_cnt == CNT_SAT);

   always_ff @(posedge sys_clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         win_cnt  <= '0;
         edge_cnt <= '0;
         prev_hit <= 1'b0;
         freq_ok  <= 1'b0;
      end else begin
         if (win_end) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
            prev_hit <= win_hit;
            freq_ok  <= win_hit & prev_hit;
         end else begin
            win_cnt <= win_cnt + 1'b1;
            if (ref_rise && !win_hit) edge_cnt <= edge_cnt + 1'b1;
         end
      end
   end

   assert_short_window_drops_R1: assert property (
      @(posedge sys_clk) disable iff (!sys_rst_n)
      (win_end && !win_hit) |=> !freq_ok);

   assert_valid_rises_at_window_R1: assert property (
      @(posedge sys_clk) disable iff (!sys_rst_n)
      $rose(freq_ok) |-> $past(win_end));

   assert_valid_needs_prior_hit_R1: assert property (
      @(posedge sys_clk) disable iff (!sys_rst_n)
      $rose(freq_ok) |-> prev_hit);

endmodule

// File: rtl/clkfan_pair_gate.sv
module clkfan_pair_gate #(
   parameter bit GLITCH_FREE = 1'b1
) (
   input  logic src_clk,
   input  logic rst_n,
   input  logic chk_clk,
   input  logic en_req,
   input  logic oe,
   output logic out_t,
   output logic out_c
);

   logic en_q;

   if (GLITCH_FREE) begin : g_low_phase
      // Enable is taken in on the falling edge, so it only changes while the clock is low.
      always_ff @(negedge src_clk or negedge rst_n) begin
         if (!rst_n) en_q <= 1'b1;
         else        en_q <= en_req;
      end
   end else begin : g_direct
      assign en_q = en_req;
   end

   assign out_t = oe & en_q & src_clk;
   assign out_c = oe & ~(en_q & src_clk);

   assert_disabled_pair_levels_R7: assert property (
      @(posedge chk_clk) disable iff (!rst_n)
      (oe && !en_q) |-> (!out_t && out_c));

endmodule

// File: rtl/clkfan_gate_ctrl.sv
module clkfan_gate_ctrl
   import clkfan_pkg::*;
#(
   parameter int WIN_CYCLES  = 200,
   parameter int MIN_EDGES   = 20,
   parameter int SYNC_STAGES = 3,
   parameter bit GLITCH_FREE = 1'b1
) (
   input  logic                 sys_clk,
   input  logic                 sys_rst_n,
   input  logic                 ref_clk,
   input  logic                 bypass_sel,
   input  logic                 pll_clk,
   input  logic [CFG_W-1:0]     cfg_bus,
   output logic [NUM_PAIRS-1:0] out_t,
   output logic [NUM_PAIRS-1:0] out_c,
   output logic                 out_oe,
   output logic                 fb_t,
   output logic                 fb_c,
   output logic                 fb_oe,
   output logic                 pll_en
);

   logic      freq_ok;
   logic      src_clk;
   pair_vec_t en_req;

   clkfan_freq_mon #(
      .WIN_CYCLES (WIN_CYCLES),
      .MIN_EDGES  (MIN_EDGES),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_freq_mon (
      .sys_clk  (sys_clk),
      .sys_rst_n(sys_rst_n),
      .ref_clk  (ref_clk),
      .freq_ok  (freq_ok)
   );

   assign src_clk = bypass_sel ? ref_clk : pll_clk;
   assign out_oe  = freq_ok;
   assign fb_oe   = freq_ok;
   assign pll_en  = freq_ok & ~bypass_sel;
   assign fb_t    = freq_ok & src_clk;
   assign fb_c    = freq_ok & ~src_clk;

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      assign en_req[p] = cfg_bus[enable_bit_pos(p)];

      clkfan_pair_gate #(
         .GLITCH_FREE(GLITCH_FREE)
      ) u_gate (
         .src_clk(src_clk),
         .rst_n  (sys_rst_n),
         .chk_clk(sys_clk),
         .en_req (en_req[p]),
         .oe     (freq_ok),
         .out_t  (out_t[p]),
         .out_c  (out_c[p])
      );
   end

   assert_invalid_quiet_R2: assert property (
      @(posedge sys_clk) disable iff (!sys_rst_n)
      !fb_oe |-> (out_t == '0 && out_c == '0 && !pll_en && !out_oe));

   assert_bypass_pll_off_R3: assert property (
      @(posedge sys_clk) disable iff (!sys_rst_n)
      bypass_sel |-> !pll_en);

   assert_feedback_pair_R8: assert property (
      @(posedge sys_clk) disable iff (!sys_rst_n)
      fb_oe |-> (fb_t != fb_c));

endmodule

// File: tb/clkfan_gate_ctrl_bench.sv
`timescale 1ns/10ps
module clkfan_gate_ctrl_bench;
   import clkfan_pkg::*;

   logic              sys_clk = 1'b0;
   logic              sys_rst_n = 1'b0;
   logic              ref_clk = 1'b0;
   logic              pll_clk = 1'b0;
   logic              bypass_sel = 1'b0;
   logic [CFG_W-1:0]  cfg_bus = '1;
   logic [NUM_PAIRS-1:0] out_t, out_c;
   logic              out_oe, fb_t, fb_c, fb_oe, pll_en;
   real               ref_half = 20.0;
   int                n_chk = 0;
   int                n_fail = 0;
   bit                done = 1'b0;

   clkfan_gate_ctrl u_clkfan_gate_ctrl (
      .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .ref_clk(ref_clk),
      .bypass_sel(bypass_sel), .pll_clk(pll_clk), .cfg_bus(cfg_bus),
      .out_t(out_t), .out_c(out_c), .out_oe(out_oe), .fb_t(fb_t),
      .fb_c(fb_c), .fb_oe(fb_oe), .pll_en(pll_en));

   always #2.5 sys_clk = ~sys_clk;
   initial begin #0.5; forever #(ref_half) ref_clk = ~ref_clk; end
   initial begin #0.25; forever #6 pll_clk = ~pll_clk; end

   task automatic chk(input bit good, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!good) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Move to a time point with fraction .1 ns, clear of every clock edge.
   task automatic align();
      real t;
      t = $realtime;
      #($floor(t) + 1.1 - t);
   endtask

   function automatic pair_vec_t exp_enables(input logic [CFG_W-1:0] cfg);
      pair_vec_t e;
      for (int p = 0; p < 8; p++) e[p] = cfg[7 - p];
      e[8] = cfg[15];
      e[9] = cfg[14];
      return e;
   endfunction

   task automatic check_outputs(input logic [CFG_W-1:0] cfg, input bit byp, input string req);
      pair_vec_t en, et, ec;
      logic src;
      for (int s = 0; s < 4; s++) begin
         align();
         #(3 * s);
         src = byp ? ref_clk : pll_clk;
         en  = exp_enables(cfg);
         et  = en & {NUM_PAIRS{src}};
         ec  = ~et;
         chk(out_t == et, {req, " true outputs"}, 32'(out_t), 32'(et));
         chk(out_c == ec, {req, " complement outputs R7"}, 32'(out_c), 32'(ec));
         chk(fb_t == src && fb_c == !src, "R8 feedback pair", {30'd0, fb_t, fb_c}, {30'd0, src, !src});
         chk(pll_en == !byp && out_oe, byp ? "R3 pll_en in bypass" : "R4 pll_en",
             {30'd0, pll_en, out_oe}, {30'd0, !byp, 1'b1});
      end
   endtask

   task automatic apply(input logic [CFG_W-1:0] cfg, input bit byp, input string req);
      cfg_bus = cfg;
      bypass_sel = byp;
      #100;
      check_outputs(cfg, byp, req);
   endtask

   task automatic check_quiet(input string req);
      align();
      chk(!out_oe && !fb_oe && !pll_en && out_t == '0 && out_c == '0 && !fb_t && !fb_c,
          req, {out_oe, fb_oe, pll_en, 9'd0, out_t, out_c[9:0]}, 32'd0);
   endtask

   initial begin
      #400000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [CFG_W-1:0] cfg;
      // Reset state (R1, R2)
      #50.1;
      check_quiet("R2 during reset");
      #2.4;
      sys_rst_n = 1'b1;
      #1500;
      check_quiet("R1 one good window is not enough");
      #1000;
      align();
      chk(out_oe && fb_oe, "R1 valid after two windows", {31'd0, out_oe}, 32'd1);

      // Walking enable and walking disable over all pairs, both source modes (R3-R7)
      for (int byp = 0; byp < 2; byp++) begin
         for (int p = 0; p < NUM_PAIRS; p++) begin
            cfg = '0;
            cfg[enable_bit_pos(p)] = 1'b1;
            apply(cfg, 1'(byp), p < 8 ? "R5 walking one" : "R6 walking one");
            cfg = '1;
            cfg[enable_bit_pos(p)] = 1'b0;
            apply(cfg, 1'(byp), p < 8 ? "R5 walking zero" : "R6 walking zero");
         end
         // Spare bits set and clear: no effect on outputs (R6)
         cfg = '0;
         cfg[7:0] = 8'hA5;
         cfg[15:14] = 2'b10;
         apply(cfg, 1'(byp), "R6 spare bits clear");
         cfg[13:8] = '1;
         cfg[CFG_W-1:16] = '1;
         apply(cfg, 1'(byp), "R6 spare bits set");
         apply('0, 1'(byp), "R7 all disabled");
      end

      // Gating only in the low phase (R9), bypass so the phase is the reference
      apply('1, 1'b1, "R3 all enabled");
      @(posedge ref_clk); #2;
      cfg_bus[7] = 1'b0;
      #1;
      chk(out_t[0] == 1'b1, "R9 high phase not cut by disable", {31'd0, out_t[0]}, 32'd1);
      @(negedge ref_clk); #1;
      chk(out_t[0] == 1'b0 && out_c[0], "R9 low after falling edge", {30'd0, out_t[0], out_c[0]}, 32'd1);
      @(posedge ref_clk); #2;
      chk(out_t[0] == 1'b0 && out_c[0], "R9 stays disabled", {30'd0, out_t[0], out_c[0]}, 32'd1);
      cfg_bus[7] = 1'b1;
      #1;
      chk(out_t[0] == 1'b0, "R9 no late start on enable", {31'd0, out_t[0]}, 32'd0);
      @(posedge ref_clk); #1;
      chk(out_t[0] == 1'b1, "R9 enable at next rising edge", {31'd0, out_t[0]}, 32'd1);

      // Slow reference forces high impedance (R1, R2), then recovery needs two windows
      bypass_sel = 1'b0;
      ref_half = 50.0;
      #2200;
      check_quiet("R2 slow reference releases outputs");
      bypass_sel = 1'b1;
      #20;
      check_quiet("R2 slow reference in bypass");
      ref_half = 20.0;
      #1100;
      check_quiet("R1 recovery needs two windows");
      #2200;
      align();
      chk(out_oe && fb_oe && !pll_en, "R1 valid again", {29'd0, out_oe, fb_oe, pll_en}, 32'd6);
      apply('1, 1'b0, "R4 recovered");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      done = 1'b1;
      $finish;
   end

endmodule